// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block decides, for each of the two ALU operands of the instruction sitting in the execute stage of a five-stage pipeline, where the operand value should come from. Its sources are the register-file read value, the result held in the execute-to-memory pipeline register (the newest producer), and the result held in the memory-to-writeback pipeline register (one instruction older). Comparing the two source register indices of the executing instruction against the destination indices and write flags of the two older in-flight instructions produces one 2-bit select per operand.

The select logic is purely combinational. A matching operand multiplexer is instantiated per operand so that the forwarded operand values are available at the ports as well as the selects. When both older instructions write the register being read, the newer one wins, so a run of back-to-back updates to one register always feeds the latest value. Register index 0 is treated as a constant-zero register and is never forwarded (this filter is a parameter). Hazard stalling and the register file itself lie outside the block.

Top module: `operand_fwd_unit`

## Requirements
- R1: With no qualifying match for an operand, its select is 2'b00 (register-file value) and its operand output equals the register-file data for that operand.
- R2: When the execute/memory write flag is high, its destination index is nonzero and equals the first source index, `fwd_a_sel` is 2'b10 and `opnd_a` equals `exm_data`.
- R3: The same rule applied to the second source index drives `fwd_b_sel` to 2'b10 and `opnd_b` to `exm_data`.
- R4: When the memory/writeback write flag is high, its destination index is nonzero and equals a source index, and the execute/memory rule for that operand does not hold, that operand's select is 2'b01 and the operand equals `mwb_data`.
- R5: When both older stages write the same nonzero register that an operand reads, the select is 2'b10 (newest producer wins).
- R6: A destination index of 0 never causes forwarding from either stage, whatever the write flags.
- R7: A low write flag disables forwarding from that stage even when its destination index matches.
- R8: The two operand selects are computed independently; both may be nonzero at once, including when both source indices are the same register.
- R9: The selector never produces 2'b11.
- R10: The operand multiplexer maps 2'b00 to register-file data, 2'b01 to writeback data, 2'b10 to execute/memory data, and falls back to register-file data on 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | REG_AW | First source register index of the executing instruction |
| src_b_idx | input | REG_AW | Second source register index of the executing instruction |
| exm_wr_en | input | 1 | Execute/memory stage will write a register |
| exm_dst_idx | input | REG_AW | Execute/memory stage destination index |
| mwb_wr_en | input | 1 | Memory/writeback stage will write a register |
| mwb_dst_idx | input | REG_AW | Memory/writeback stage destination index |
| rf_a_data | input | DATA_W | Register-file read value for operand A |
| rf_b_data | input | DATA_W | Register-file read value for operand B |
| exm_data | input | DATA_W | Result held in the execute/memory register |
| mwb_data | input | DATA_W | Result held in the memory/writeback register |
| fwd_a_sel | output | 2 | Operand A source select |
| fwd_b_sel | output | 2 | Operand B source select |
| opnd_a | output | DATA_W | Forwarded operand A |
| opnd_b | output | DATA_W | Forwarded operand B |

## Verification
The bench aims at the double-producer case, where a design that checked the writeback stage first would hand the executing instruction a stale value from one instruction earlier. It drives destination index 0 with write flags high, which a design lacking the zero filter would wrongly forward, and matching indices with write flags low, which an ungated comparator would forward. It reads the same register through both operands to catch one select leaking into the other, and drives the multiplexer directly with 2'b11 to confirm the register-file fallback; randomized traffic over a narrow index range then exercises all of these mixtures against a reference model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_WBACK   = 2'b01,
      SRC_EXMEM   = 2'b10,
      SRC_UNUSED  = 2'b11
   } fwd_src_e;

   localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW    = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_idx,
   input  logic              exm_wr_en,
   input  logic [REG_AW-1:0] exm_dst_idx,
   input  logic              mwb_wr_en,
   input  logic [REG_AW-1:0] mwb_dst_idx,
   output logic [SEL_W-1:0]  sel
);

   logic exm_live;
   logic mwb_live;
   logic exm_hit;
   logic mwb_hit;

   generate
      if (ZERO_HARD) begin : g_zero_filter
         assign exm_live = exm_wr_en && (exm_dst_idx != '0);
         assign mwb_live = mwb_wr_en && (mwb_dst_idx != '0);
      end else begin : g_no_filter
         assign exm_live = exm_wr_en;
         assign mwb_live = mwb_wr_en;
      end
   endgenerate

   assign exm_hit = exm_live && (exm_dst_idx == src_idx);
   assign mwb_hit = mwb_live && (mwb_dst_idx == src_idx);

   always_comb begin
      fwd_src_e pick;
      pick = SRC_REGFILE;
      if (exm_hit) begin
         pick = SRC_EXMEM;
      end else if (mwb_hit) begin
         pick = SRC_WBACK;
      end
      sel = pick;
   end

endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
   import fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] rf_data,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [DATA_W-1:0] ex_data,
   output logic [DATA_W-1:0] opnd
);

   always_comb begin
      unique case (fwd_src_e'(sel))
         SRC_EXMEM:   opnd = ex_data;
         SRC_WBACK:   opnd = wb_data;
         SRC_REGFILE: opnd = rf_data;
         default:     opnd = rf_data;
      endcase
   end

   always_comb begin
      // R10
      mux_fallback_chk : assert ((sel != 2'b11) || (opnd == rf_data))
         else $error("reserved select did not fall back to register file");
   end

endmodule

// File: rtl/operand_fwd_unit.sv
module operand_fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_a_idx,
   input  logic [REG_AW-1:0] src_b_idx,
   input  logic              exm_wr_en,
   input  logic [REG_AW-1:0] exm_dst_idx,
   input  logic              mwb_wr_en,
   input  logic [REG_AW-1:0] mwb_dst_idx,
   input  logic [DATA_W-1:0] rf_a_data,
   input  logic [DATA_W-1:0] rf_b_data,
   input  logic [DATA_W-1:0] exm_data,
   input  logic [DATA_W-1:0] mwb_data,
   output logic [1:0]        fwd_a_sel,
   output logic [1:0]        fwd_b_sel,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);

   localparam int unsigned N_OPND = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic [REG_AW-1:0] src_idx [N_OPND];
   logic [DATA_W-1:0] rf_data [N_OPND];
   logic [SEL_W-1:0]  sel     [N_OPND];
   logic [DATA_W-1:0] opnd    [N_OPND];

   assign src_idx[0] = src_a_idx;
   assign src_idx[1] = src_b_idx;
   assign rf_data[0] = rf_a_data;
   assign rf_data[1] = rf_b_data;

   generate
      for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
         fwd_match #(
            .REG_AW   (REG_AW),
            .ZERO_HARD(ZERO_HARD)
         ) u_match (
            .src_idx    (src_idx[gi]),
            .exm_wr_en  (exm_wr_en),
            .exm_dst_idx(exm_dst_idx),
            .mwb_wr_en  (mwb_wr_en),
            .mwb_dst_idx(mwb_dst_idx),
            .sel        (sel[gi])
         );

         fwd_opnd_mux #(
            .DATA_W(DATA_W)
         ) u_mux (
            .sel    (sel[gi]),
            .rf_data(rf_data[gi]),
            .wb_data(mwb_data),
            .ex_data(exm_data),
            .opnd   (opnd[gi])
         );

         always_comb begin
            // R9
            sel_legal_chk : assert (sel[gi] != 2'b11)
               else $error("reserved select produced");
            // R2 R3 R5
            ex_src_chk : assert ((sel[gi] != 2'b10) ||
                                 (exm_wr_en && exm_dst_idx == src_idx[gi]))
               else $error("execute forward without matching writer");
            // R4
            wb_src_chk : assert ((sel[gi] != 2'b01) ||
                                 (mwb_wr_en && mwb_dst_idx == src_idx[gi] &&
                                  !(exm_wr_en && exm_dst_idx == src_idx[gi] &&
                                    (!ZERO_HARD || exm_dst_idx != '0))))
               else $error("writeback forward chosen over newer producer");
            // R6
            zero_reg_chk : assert (!ZERO_HARD || src_idx[gi] != '0 ||
                                   sel[gi] == 2'b00)
               else $error("register zero forwarded");
         end
      end
   endgenerate

   assign fwd_a_sel = sel[0];
   assign fwd_b_sel = sel[1];
   assign opnd_a    = opnd[0];
   assign opnd_b    = opnd[1];

endmodule

// File: tb/operand_fwd_unit_bench.sv
module operand_fwd_unit_bench;

   localparam int  CLK_PERIOD = 10;
   localparam int  AW = 5;
   localparam int  DW = 32;

   typedef struct {
      logic [1:0]    a_sel;
      logic [1:0]    b_sel;
      logic [DW-1:0] a_val;
      logic [DW-1:0] b_val;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0] src_a_idx = '0, src_b_idx = '0, exm_dst_idx = '0, mwb_dst_idx = '0;
   logic          exm_wr_en = 1'b0, mwb_wr_en = 1'b0;
   logic [DW-1:0] rf_a_data = '0, rf_b_data = '0, exm_data = '0, mwb_data = '0;
   logic [1:0]    fwd_a_sel, fwd_b_sel;
   logic [DW-1:0] opnd_a, opnd_b;

   logic [1:0]    m_sel = 2'b00;
   logic [DW-1:0] m_out;

   int checks = 0;
   int errors = 0;
   exp_t sb[$];
   bit   drv_done = 1'b0;

   operand_fwd_unit u_operand_fwd_unit (
      .src_a_idx, .src_b_idx, .exm_wr_en, .exm_dst_idx, .mwb_wr_en,
      .mwb_dst_idx, .rf_a_data, .rf_b_data, .exm_data, .mwb_data,
      .fwd_a_sel, .fwd_b_sel, .opnd_a, .opnd_b
   );

   fwd_opnd_mux #(.DATA_W(DW)) u_mux_direct (
      .sel(m_sel), .rf_data(32'h1111_0000), .wb_data(32'h2222_0000),
      .ex_data(32'h3333_0000), .opnd(m_out)
   );

   function automatic logic [1:0] ref_sel(logic [AW-1:0] s);
      if (exm_wr_en && exm_dst_idx != 0 && exm_dst_idx == s) return 2'b10;
      if (mwb_wr_en && mwb_dst_idx != 0 && mwb_dst_idx == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic [DW-1:0] ref_val(logic [1:0] s, logic [DW-1:0] rf);
      case (s)
         2'b10:   return exm_data;
         2'b01:   return mwb_data;
         default: return rf;
      endcase
   endfunction

   task automatic apply(input logic [AW-1:0] sa, input logic [AW-1:0] sb_i,
                        input logic ew, input logic [AW-1:0] ed,
                        input logic ww, input logic [AW-1:0] wd,
                        input string tag);
      exp_t e;
      @(posedge clk);
      src_a_idx = sa; src_b_idx = sb_i;
      exm_wr_en = ew; exm_dst_idx = ed;
      mwb_wr_en = ww; mwb_dst_idx = wd;
      rf_a_data = $urandom; rf_b_data = $urandom;
      exm_data = $urandom; mwb_data = $urandom;
      e.a_sel = ref_sel(sa);
      e.b_sel = ref_sel(sb_i);
      e.a_val = ref_val(e.a_sel, rf_a_data);
      e.b_val = ref_val(e.b_sel, rf_b_data);
      e.tag   = tag;
      sb.push_back(e);
   endtask

   task automatic chk(input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: samples on the falling edge, after inputs settled
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " sel_a"}, 32'(fwd_a_sel), 32'(e.a_sel));
            chk({e.tag, " sel_b"}, 32'(fwd_b_sel), 32'(e.b_sel));
            chk({e.tag, " opnd_a"}, opnd_a, e.a_val);
            chk({e.tag, " opnd_b"}, opnd_b, e.b_val);
            // R9
            chk({e.tag, " R9 no 11 on a"}, 32'(fwd_a_sel == 2'b11), 32'd0);
         end
      end
   end

   // driver
   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      apply(0, 0, 0, 0, 0, 0, "R1 reset-idle");
      apply(4, 7, 0, 9, 0, 10, "R1 no match");
      apply(3, 8, 1, 3, 0, 0, "R2 ex to A");
      apply(8, 3, 1, 3, 0, 0, "R3 ex to B");
      apply(6, 2, 0, 0, 1, 6, "R4 wb to A");
      apply(2, 6, 0, 0, 1, 6, "R4 wb to B");
      apply(1, 1, 1, 1, 1, 1, "R5 double producer same reg");
      apply(5, 9, 1, 5, 1, 5, "R5 newest wins A");
      apply(0, 0, 1, 0, 1, 0, "R6 zero dest both stages");
      apply(0, 4, 1, 0, 1, 4, "R6 zero dest ex, wb valid on B");
      apply(7, 7, 0, 7, 0, 7, "R7 write flags low");
      apply(7, 9, 0, 7, 1, 7, "R7 ex disabled falls to wb");
      apply(2, 2, 1, 2, 0, 0, "R8 same reg both operands");
      apply(4, 5, 1, 4, 1, 5, "R8 A from ex B from wb");
      for (int i = 0; i < 400; i++) begin
         apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
               1'($urandom), 5'($urandom_range(0, 3)),
               1'($urandom), 5'($urandom_range(0, 3)), "R8 random mix");
      end
      @(posedge clk);
      // R10 direct multiplexer sweep, including reserved code
      for (int s = 0; s < 4; s++) begin
         @(posedge clk);
         m_sel = 2'(s);
         @(negedge clk);
         chk($sformatf("R10 mux sel=%0d", s), m_out,
             (s == 1) ? 32'h2222_0000 : (s == 2) ? 32'h3333_0000 : 32'h1111_0000);
      end
      @(negedge clk);
      drv_done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!drv_done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!drv_done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule